// File: doc/BRIEF.md
# Six-Button Game Pad Responder

This block plays the controller side of a multiplexed game pad that carries twelve buttons over six data lines. The host drives a select line and reads back a 7-bit value. That value holds six active-low button bits plus an echo of the select level. In three-button mode, the select level alone picks one of two button groups.

In six-button mode, a small phase counter advances on every rising edge of the select line. At the higher phases the low nibble is replaced, first by zeros, then by the mode/X/Y/Z group, and finally by an all-ones marker. Once no select edge and no host write has arrived for a programmable number of cycles, an idle counter returns the phase to zero. Each host write restarts that idle count.

The output is combinational from the select input, the button inputs and the registered phase. A host can therefore read the port in the same cycle it changes the select level.

Top module: `pad6_responder`

## Requirements
- R1: With select high and the phase view in its default form, pad_out[5:0] is the inverse of {C, B, right, left, down, up}. Buttons are active-high on btn_in, where bit 0 is up, 1 down, 2 left, 3 right, 4 B, 5 C, 6 A, 7 start, 8 Z, 9 Y, 10 X and 11 mode.
- R2: With select low and the default view, pad_out[5:4] is the inverse of {start, A}, pad_out[3:2] is 0, and pad_out[1:0] is the inverse of {down, up}.
- R3: A clock edge at which sel_in is high after being low in the previous cycle raises the phase by one. The phase saturates at 3.
- R4: In six-button mode at phase 2 with select low, pad_out[5:4] is the inverse of {start, A} and pad_out[3:0] is 0.
- R5: In six-button mode at phase 3 with select high, pad_out[5:4] is the inverse of {C, B} and pad_out[3:0] is the inverse of {mode, X, Y, Z}.
- R6: In six-button mode at phase 3 with select low, pad_out[5:4] is the inverse of {start, A} and pad_out[3:0] is 4'hF.
- R7: pad_out[6] always equals sel_in.
- R8: A clock edge with host_wr high sets the idle count to zero.
- R9: If neither a host write nor a select rise occurs for idle_limit+1 consecutive clock edges after the last one, the phase returns to 0. After only idle_limit such edges, the phase is still held.
- R10: With six_mode low, the phase has no effect and only the default mapping of R1 and R2 applies.
- R11: Reset clears the phase and the idle count and treats the select line as previously high. The first high level after reset therefore does not count as a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| six_mode | input | 1 | 1 selects six-button behaviour, 0 three-button |
| sel_in | input | 1 | Select line driven by the host |
| host_wr | input | 1 | Strobe for a host write to the port |
| idle_limit | input | IDLE_W | Idle cycles allowed before the phase resets |
| btn_in | input | 12 | Active-high buttons, ordered as in R1 |
| pad_out | output | 7 | Select echo in bit 6, active-low data in bits 5..0 |

## Verification
The assertions assume that sel_in and host_wr are stable around the rising clock edge. They also assume that idle_limit does not change while a count is in progress, because the checks on counter increments compare the count against the current limit. The bench changes every input on the falling edge only and holds idle_limit constant for the whole run. Every select change in the stimulus table comes with a host write, which matches how a host drives the port. The idle-timeout tests deliberately stop issuing writes.

// File: rtl/pad6_pkg.sv
package pad6_pkg;
  localparam int BTN_N   = 12;
  localparam int PHASE_W = 2;
  localparam int OUT_W   = 7;
  localparam logic [PHASE_W-1:0] PHASE_MAX = '1;

  // Output word for one read: select echo plus six active-low data bits.
  function automatic logic [OUT_W-1:0] pad_view(
    input logic [BTN_N-1:0]   btn,
    input logic               sel,
    input logic [PHASE_W-1:0] phase,
    input logic               six
  );
    logic [BTN_N-1:0] n;
    logic [5:0] d;
    n = ~btn;
    if (six && phase == 2'd3)
      d = sel ? {n[5], n[4], n[11:8]} : {n[7], n[6], 4'hF};
    else if (six && phase == 2'd2 && !sel)
      d = {n[7], n[6], 4'h0};
    else
      d = sel ? n[5:0] : {n[7], n[6], 2'b00, n[1], n[0]};
    return {sel, d};
  endfunction

  // Next phase: a select rise wins, saturating; a timeout returns to zero.
  function automatic logic [PHASE_W-1:0] phase_next(
    input logic [PHASE_W-1:0] phase,
    input logic               rise,
    input logic               timeout
  );
    if (rise)
      return (phase == PHASE_MAX) ? phase : phase + 1'b1;
    else if (timeout)
      return '0;
    return phase;
  endfunction
endpackage

// File: rtl/pad6_edge.sv
module pad6_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_in,
  output logic sel_rise
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b1;
    else        sel_q <= sel_in;
  end

  assign sel_rise = sel_in & ~sel_q;

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> !$past(sel_in, 2) || $past(sel_rise) == 1'b0); // R3
endmodule

// File: rtl/pad6_idle.sv
module pad6_idle #(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              sel_rise,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              idle_timeout
);
  logic [IDLE_W-1:0] idle_cnt;
  logic              idle_clear;
  logic              idle_full;

  assign idle_clear   = host_wr | sel_rise;
  assign idle_full    = (idle_cnt >= idle_limit);
  assign idle_timeout = ~idle_clear & idle_full;

  always_ff @(posedge clk) begin
    if (!rst_n)          idle_cnt <= '0;
    else if (idle_clear) idle_cnt <= '0;
    else if (!idle_full) idle_cnt <= idle_cnt + 1'b1;
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> idle_cnt == '0); // R8
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !sel_rise && idle_cnt < idle_limit) |=> idle_cnt == $past(idle_cnt) + 1'b1); // R9
  AST_IDLE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_clear && idle_full && $stable(idle_limit)) |=> idle_cnt == $past(idle_cnt)); // R9
endmodule

// File: rtl/pad6_phase.sv
module pad6_phase
  import pad6_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_rise,
  input  logic               idle_timeout,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_next(phase, sel_rise, idle_timeout);
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && phase != PHASE_MAX) |=> phase == $past(phase) + 1'b1); // R3
  AST_PHASE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && phase == PHASE_MAX) |=> phase == PHASE_MAX); // R3
  AST_PHASE_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    idle_timeout |=> phase == '0); // R9
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_rise && !idle_timeout) |=> $stable(phase)); // R9
endmodule

// File: rtl/pad6_responder.sv
module pad6_responder
  import pad6_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              six_mode,
  input  logic              sel_in,
  input  logic              host_wr,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [BTN_N-1:0]  btn_in,
  output logic [OUT_W-1:0]  pad_out
);
  logic               sel_rise;
  logic               idle_timeout;
  logic [PHASE_W-1:0] phase;

  pad6_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_in   (sel_in),
    .sel_rise (sel_rise)
  );

  pad6_idle #(.IDLE_W(IDLE_W)) u_idle (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .sel_rise     (sel_rise),
    .idle_limit   (idle_limit),
    .idle_timeout (idle_timeout)
  );

  pad6_phase u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_rise     (sel_rise),
    .idle_timeout (idle_timeout),
    .phase        (phase)
  );

  assign pad_out = pad_view(btn_in, sel_in, phase, six_mode);

  AST_SEL_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    pad_out[6] == sel_in); // R7
  AST_THREE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!six_mode && !sel_in) |-> pad_out[3:2] == 2'b00); // R10
  AST_THREE_HIGH_DPAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!six_mode && sel_in) |-> pad_out[3:0] == ~btn_in[3:0]); // R10
  AST_MARKER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (six_mode && !sel_in && pad_out[3:0] == 4'hF) |-> phase == PHASE_MAX); // R6
endmodule

// File: tb/test_pad6_responder.sv
`timescale 1ns/1ps
module test_pad6_responder;
  localparam int IDLE_W = 8;
  localparam int LIM    = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              six_mode = 1'b1;
  logic              sel_in = 1'b1;
  logic              host_wr = 1'b0;
  logic [IDLE_W-1:0] idle_limit = IDLE_W'(LIM);
  logic [11:0]       btn_in = '0;
  logic [6:0]        pad_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pad6_responder #(.IDLE_W(IDLE_W)) i_pad6_responder (
    .clk(clk), .rst_n(rst_n), .six_mode(six_mode), .sel_in(sel_in),
    .host_wr(host_wr), .idle_limit(idle_limit), .btn_in(btn_in), .pad_out(pad_out)
  );

  // View codes: 0 default high, 1 default low, 2 phase-2 low, 3 phase-3 high, 4 phase-3 low
  localparam logic [3:0] SEQ [0:8] = '{
    {1'b0, 3'd1}, {1'b1, 3'd0}, {1'b0, 3'd1}, {1'b1, 3'd0}, {1'b0, 3'd2},
    {1'b1, 3'd3}, {1'b0, 3'd4}, {1'b1, 3'd3}, {1'b0, 3'd4}
  };

  function automatic logic [6:0] expect_out(input logic [11:0] b, input logic th,
                                            input logic [2:0] view, input logic six);
    logic up, dn, lf, rt, kb, kc, ka, st, kz, ky, kx, md;
    logic [2:0] v;
    {md, kx, ky, kz, st, ka, kc, kb, rt, lf, dn, up} = b;
    v = six ? view : (th ? 3'd0 : 3'd1);
    case (v)
      3'd0:    return {1'b1, !kc, !kb, !rt, !lf, !dn, !up};
      3'd1:    return {1'b0, !st, !ka, 1'b0, 1'b0, !dn, !up};
      3'd2:    return {1'b0, !st, !ka, 4'b0000};
      3'd3:    return {1'b1, !kc, !kb, !md, !kx, !ky, !kz};
      default: return {1'b0, !st, !ka, 4'b1111};
    endcase
  endfunction

  task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: pad_out=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic th, input logic [11:0] b);
    @(negedge clk);
    sel_in = th; btn_in = b; host_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    #1;
  endtask

  task automatic run_table(input logic six, input string tag);
    for (int i = 0; i < 9; i++) begin
      logic [11:0] b;
      b = 12'hA5C ^ 12'(i * 12'h1F3);
      step(SEQ[i][3], b);
      check(tag, pad_out, expect_out(b, SEQ[i][3], SEQ[i][2:0], six));
    end
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic reach_phase3(input logic [11:0] b);
    for (int i = 0; i < 6; i++) step(SEQ[i][3], b);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: pad_out=%h expected=done", pad_out);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] b;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R11 reset idle", pad_out, 7'h7F);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 no rise after reset", pad_out, 7'h7F);

    six_mode = 1'b1;
    run_table(1'b1, "R1 R2 R3 R4 R5 R6 R7 six-button table");

    @(negedge clk); sel_in = 1'b1;
    idle_wait(LIM + 3);
    six_mode = 1'b0;
    run_table(1'b0, "R10 three-button table");

    // R9 boundary: held for LIM edges, cleared at LIM+1
    @(negedge clk); sel_in = 1'b1; six_mode = 1'b1;
    idle_wait(LIM + 3);
    b = 12'h3C6;
    reach_phase3(b);
    check("R5 phase3 high", pad_out, expect_out(b, 1'b1, 3'd3, 1'b1));
    sel_in = 1'b0;
    idle_wait(LIM);
    check("R9 held at limit", pad_out, expect_out(b, 1'b0, 3'd4, 1'b1));
    idle_wait(1);
    check("R9 timeout to phase 0", pad_out, expect_out(b, 1'b0, 3'd1, 1'b1));

    // R8: a write restarts the idle count
    sel_in = 1'b1;
    b = 12'hFFF;
    reach_phase3(b);
    sel_in = 1'b0;
    idle_wait(LIM - 2);
    host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
    idle_wait(LIM);
    check("R8 write restarts idle", pad_out, expect_out(b, 1'b0, 3'd4, 1'b1));
    idle_wait(1);
    check("R8 timeout after write", pad_out, expect_out(b, 1'b0, 3'd1, 1'b1));

    // R7 and R1 with all buttons pressed, select high at phase 0
    sel_in = 1'b1; #1;
    check("R7 R1 all pressed high", pad_out, 7'h40);

    // R11: reset in the middle clears phase
    b = 12'h000;
    reach_phase3(b);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk); rst_n = 1'b1; sel_in = 1'b0; #1;
    check("R11 reset clears phase", pad_out, expect_out(b, 1'b0, 3'd1, 1'b1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule